// File: doc/BRIEF.md
# Last-Writer Dependency Window

This block tracks register dependencies for one execution cluster. It keeps one table slot per architectural register. Each slot holds the tag of the youngest in-flight instruction that will write that register. When dispatch hands over an instruction, both of its source registers are looked up in the table. Each valid hit makes the newcomer wait on that producer. The newcomer's own destination then takes over the table slot, so only the newest writer of a register is ever remembered.

Waiting instructions sit in a small window of slots. Each slot holds a count of the producers it still waits on. A completion reports only its tag. That tag is broadcast to every waiting slot, and each slot lowers its count once for every source that named the tag. A slot whose count is zero waits a fixed number of cycles, then becomes eligible to go to execution. It leaves the window in the cycle it issues.

A completion also clears the table slot that still holds the finishing tag, and only that slot. It also sets the tag's bit in an executed mask, which later retirement logic reads. Dispatch sees a full flag and must not rely on an insertion made while that flag is high. Register 0 is never tracked.

Top module: `dep_window`

## Requirements
- R1: After reset the window holds no instruction: `win_full` and `issue_valid` are low and every bit of `done_mask` is 0.
- R2: An instruction accepted with no pending producer drives `issue_valid` with its tag in the cycle that follows the SCHED_LAT-th rising edge after the edge that accepted it.
- R3: Each source whose register holds a valid table entry adds one pending producer. The instruction issues in the cycle after the SCHED_LAT-th edge following the completion that removes its last pending producer. When both sources name the same producer, that one completion satisfies both.
- R4: Source lookups use the table as it stood before the instruction's own destination write. An instruction that reads and writes the same register therefore waits on the older writer, and later readers of that register wait on it.
- R5: A completion clears a register's table entry only when the entry still holds the completing tag. An entry taken over by a younger writer survives, and readers keep waiting on that younger writer.
- R6: Register 0 is never recorded as a producer. A source of 0 never waits, and a destination of 0 leaves the table unchanged.
- R7: When a completion and an accepted insertion happen on the same edge, a source lookup that hits the completing tag counts as already satisfied. If the insertion's destination is the register being cleared, the insertion's write wins.
- R8: Bit t of `done_mask` is set by a completion with tag t. It is cleared when an instruction with tag t is accepted, and it stays clear until that instruction completes.
- R9: The window has WIN slots, and `win_full` is high while all of them are occupied. An insertion made while `win_full` is high is dropped: it takes no slot, never issues and writes nothing into the table. A slot is freed on the edge after its instruction issues.
- R10: At most one instruction issues per cycle. Among the eligible slots, the lowest-numbered one issues first. A new instruction takes the lowest-numbered free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Dispatch presents an instruction |
| ins_src_a | input | REG_W | First source register |
| ins_src_b | input | REG_W | Second source register |
| ins_dst | input | REG_W | Destination register |
| ins_tag | input | TAG_W | Unique in-flight tag of the instruction |
| cmp_valid | input | 1 | An instruction finished execution |
| cmp_tag | input | TAG_W | Tag of the finished instruction |
| win_full | output | 1 | Every window slot is occupied |
| issue_valid | output | 1 | An instruction is sent to execution this cycle |
| issue_tag | output | TAG_W | Tag of the issued instruction |
| done_mask | output | NUM_TAGS | Executed flag per tag |

## Verification
The bench goes after the clear on completion. A younger writer of the same register must keep its table entry when the older writer finishes. A design that cleared by register would release a reader too early, and the scoreboard would see an issue it did not expect. The bench also exercises the same-edge overlap of a completion with an insertion that reads and rewrites the completing register. If the wakeup were lost, the inserted instruction would hang. If the clear won over the write, the next reader would issue before its producer finished. The remaining cases are a source that names the same register twice, a read-and-write of one register, and register 0. Last come a full window, the dropped insertion, whose table write would strand a later reader, and the order in which four slots that become ready together are issued.

// File: rtl/dw_pkg.sv
package dw_pkg;

    // Default sizing of the dependency window.
    localparam int DW_NUM_REGS   = 32;
    localparam int DW_NUM_TAGS   = 16;
    localparam int DW_WIN        = 8;
    localparam int DW_SCHED_LAT  = 2;

    // Number of producers a newly inserted instruction still waits on.
    function automatic logic [1:0] dw_pending(input logic wait_a, input logic wait_b);
        return {1'b0, wait_a} + {1'b0, wait_b};
    endfunction

    // Pending count after the wakeups of one completion broadcast.
    function automatic logic [1:0] dw_after_wake(input logic [1:0] pend,
                                                 input logic hit_a, input logic hit_b);
        return pend - {1'b0, hit_a} - {1'b0, hit_b};
    endfunction

endpackage

// File: rtl/dw_first_set.sv
module dw_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest-numbered set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dw_writer_table.sv
module dw_writer_table #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] look_a,
    input  logic [REG_W-1:0] look_b,
    output logic             hit_a,
    output logic [TAG_W-1:0] tag_a,
    output logic             hit_b,
    output logic [TAG_W-1:0] tag_b,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag
);
    logic [NUM_REGS-1:0]            live;
    logic [NUM_REGS-1:0][TAG_W-1:0] owner;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            // Register 0 carries no dependency.
            assign live[r]  = 1'b0;
            assign owner[r] = '0;
        end else begin : g_track
            logic             live_q;
            logic [TAG_W-1:0] owner_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    live_q  <= 1'b0;
                    owner_q <= '0;
                end else begin
                    // Clear only when the finishing tag still owns the register.
                    if (clr_en && live_q && owner_q == clr_tag)
                        live_q <= 1'b0;
                    // A new writer takes precedence over a same-edge clear.
                    if (wr_en && wr_reg == REG_W'(r)) begin
                        live_q  <= 1'b1;
                        owner_q <= wr_tag;
                    end
                end
            end
            assign live[r]  = live_q;
            assign owner[r] = owner_q;
        end
    end

    // Lookups see the table before this edge's updates.
    assign hit_a = live[look_a];
    assign tag_a = owner[look_a];
    assign hit_b = live[look_b];
    assign tag_b = owner[look_b];
endmodule

// File: rtl/dw_slot_array.sv
module dw_slot_array import dw_pkg::*; #(
    parameter int WIN       = 8,
    parameter int TAG_W     = 4,
    parameter int SCHED_LAT = 2,
    localparam int IDX_W    = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int TMR_W    = $clog2(SCHED_LAT + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc_en,
    input  logic [IDX_W-1:0]          alloc_idx,
    input  logic [TAG_W-1:0]          new_tag,
    input  logic                      new_wait_a,
    input  logic [TAG_W-1:0]          new_prod_a,
    input  logic                      new_wait_b,
    input  logic [TAG_W-1:0]          new_prod_b,
    input  logic                      wake_en,
    input  logic [TAG_W-1:0]          wake_tag,
    input  logic                      grant_en,
    input  logic [IDX_W-1:0]          grant_idx,
    output logic [WIN-1:0]            occ,
    output logic [WIN-1:0]            elig,
    output logic [WIN-1:0][TAG_W-1:0] slot_tag
);
    typedef struct packed {
        logic             busy;
        logic [TAG_W-1:0] tag;
        logic             wait_a;
        logic [TAG_W-1:0] prod_a;
        logic             wait_b;
        logic [TAG_W-1:0] prod_b;
        logic [1:0]       pend;
        logic [TMR_W-1:0] tmr;
    } slot_t;

    for (genvar i = 0; i < WIN; i++) begin : g_slot
        slot_t      s_q;
        logic       wk_a;
        logic       wk_b;
        logic [1:0] pend_nx;

        always_comb begin
            wk_a    = wake_en && s_q.wait_a && s_q.prod_a == wake_tag;
            wk_b    = wake_en && s_q.wait_b && s_q.prod_b == wake_tag;
            pend_nx = dw_after_wake(s_q.pend, wk_a, wk_b);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                s_q.busy   <= 1'b1;
                s_q.tag    <= new_tag;
                s_q.wait_a <= new_wait_a;
                s_q.prod_a <= new_prod_a;
                s_q.wait_b <= new_wait_b;
                s_q.prod_b <= new_prod_b;
                s_q.pend   <= dw_pending(new_wait_a, new_wait_b);
                s_q.tmr    <= TMR_W'(SCHED_LAT);
            end else if (s_q.busy) begin
                if (grant_en && grant_idx == IDX_W'(i)) begin
                    s_q.busy <= 1'b0;
                end else begin
                    if (wk_a) s_q.wait_a <= 1'b0;
                    if (wk_b) s_q.wait_b <= 1'b0;
                    s_q.pend <= pend_nx;
                    // Scheduling penalty restarts when the last producer completes.
                    if (s_q.pend != 2'd0 && pend_nx == 2'd0)
                        s_q.tmr <= TMR_W'(SCHED_LAT);
                    else if (s_q.pend == 2'd0 && s_q.tmr != '0)
                        s_q.tmr <= s_q.tmr - 1'b1;
                end
            end
        end

        assign occ[i]      = s_q.busy;
        assign elig[i]     = s_q.busy && s_q.pend == 2'd0 && s_q.tmr == '0;
        assign slot_tag[i] = s_q.tag;
    end
endmodule

// File: rtl/dep_window.sv
module dep_window import dw_pkg::*; #(
    parameter int NUM_REGS  = DW_NUM_REGS,
    parameter int NUM_TAGS  = DW_NUM_TAGS,
    parameter int WIN       = DW_WIN,
    parameter int SCHED_LAT = DW_SCHED_LAT,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ins_valid,
    input  logic [REG_W-1:0]    ins_src_a,
    input  logic [REG_W-1:0]    ins_src_b,
    input  logic [REG_W-1:0]    ins_dst,
    input  logic [TAG_W-1:0]    ins_tag,
    input  logic                cmp_valid,
    input  logic [TAG_W-1:0]    cmp_tag,
    output logic                win_full,
    output logic                issue_valid,
    output logic [TAG_W-1:0]    issue_tag,
    output logic [NUM_TAGS-1:0] done_mask
);
    localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;

    logic                      accept;
    logic                      hit_a, hit_b;
    logic [TAG_W-1:0]          tag_a, tag_b;
    logic                      wait_a, wait_b;
    logic [WIN-1:0]            occ, elig;
    logic [WIN-1:0][TAG_W-1:0] slot_tag;
    logic                      free_found, gnt_found;
    logic [IDX_W-1:0]          free_idx, gnt_idx;

    assign win_full = &occ;
    assign accept   = ins_valid && !win_full;

    dw_writer_table #(
        .NUM_REGS (NUM_REGS),
        .TAG_W    (TAG_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .look_a  (ins_src_a),
        .look_b  (ins_src_b),
        .hit_a   (hit_a),
        .tag_a   (tag_a),
        .hit_b   (hit_b),
        .tag_b   (tag_b),
        .wr_en   (accept),
        .wr_reg  (ins_dst),
        .wr_tag  (ins_tag),
        .clr_en  (cmp_valid),
        .clr_tag (cmp_tag)
    );

    // A producer finishing on this very edge is already satisfied.
    always_comb begin
        wait_a = hit_a && !(cmp_valid && tag_a == cmp_tag);
        wait_b = hit_b && !(cmp_valid && tag_b == cmp_tag);
    end

    dw_first_set #(.N(WIN), .IDX_W(IDX_W)) u_alloc_pick (
        .req   (~occ),
        .found (free_found),
        .idx   (free_idx)
    );

    dw_first_set #(.N(WIN), .IDX_W(IDX_W)) u_issue_pick (
        .req   (elig),
        .found (gnt_found),
        .idx   (gnt_idx)
    );

    dw_slot_array #(
        .WIN       (WIN),
        .TAG_W     (TAG_W),
        .SCHED_LAT (SCHED_LAT)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (accept && free_found),
        .alloc_idx  (free_idx),
        .new_tag    (ins_tag),
        .new_wait_a (wait_a),
        .new_prod_a (tag_a),
        .new_wait_b (wait_b),
        .new_prod_b (tag_b),
        .wake_en    (cmp_valid),
        .wake_tag   (cmp_tag),
        .grant_en   (gnt_found),
        .grant_idx  (gnt_idx),
        .occ        (occ),
        .elig       (elig),
        .slot_tag   (slot_tag)
    );

    assign issue_valid = gnt_found;
    assign issue_tag   = slot_tag[gnt_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            done_mask <= '0;
        end else begin
            if (cmp_valid) done_mask[cmp_tag] <= 1'b1;
            if (accept)    done_mask[ins_tag] <= 1'b0;
        end
    end
endmodule

// File: rtl/dw_checker.sv
module dw_checker #(
    parameter int NUM_TAGS = 16,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                ins_valid,
    input logic [TAG_W-1:0]    ins_tag,
    input logic                cmp_valid,
    input logic [TAG_W-1:0]    cmp_tag,
    input logic                win_full,
    input logic                issue_valid,
    input logic [TAG_W-1:0]    issue_tag,
    input logic [NUM_TAGS-1:0] done_mask
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $fell(rst) |-> (!issue_valid && !win_full && done_mask == '0)); // R1

    AST_NO_EARLY_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !win_full) |=> !(issue_valid && issue_tag == $past(ins_tag))); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (win_full && !issue_valid) |=> win_full); // R9

    AST_DONE_AFTER_CMP: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !(ins_valid && !win_full && ins_tag == cmp_tag))
        |=> done_mask[$past(cmp_tag)]); // R8

    AST_ISSUE_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> !done_mask[issue_tag]); // R8
endmodule

bind dep_window dw_checker #(.NUM_TAGS(NUM_TAGS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ins_valid   (ins_valid),
    .ins_tag     (ins_tag),
    .cmp_valid   (cmp_valid),
    .cmp_tag     (cmp_tag),
    .win_full    (win_full),
    .issue_valid (issue_valid),
    .issue_tag   (issue_tag),
    .done_mask   (done_mask)
);

// File: tb/tb_dep_window.sv
module tb_dep_window;
    localparam int NREG = 32;
    localparam int NTAG = 32;
    localparam int WIN  = 4;
    localparam int LAT  = 2;
    localparam int RW   = $clog2(NREG);
    localparam int TW   = $clog2(NTAG);

    logic            clk = 1'b0;
    logic            rst;
    logic            ins_valid;
    logic [RW-1:0]   ins_src_a, ins_src_b, ins_dst;
    logic [TW-1:0]   ins_tag;
    logic            cmp_valid;
    logic [TW-1:0]   cmp_tag;
    logic            win_full;
    logic            issue_valid;
    logic [TW-1:0]   issue_tag;
    logic [NTAG-1:0] done_mask;

    always #5 clk = ~clk;

    dep_window #(
        .NUM_REGS (NREG), .NUM_TAGS (NTAG), .WIN (WIN), .SCHED_LAT (LAT)
    ) dut (
        .clk (clk), .rst (rst),
        .ins_valid (ins_valid), .ins_src_a (ins_src_a), .ins_src_b (ins_src_b),
        .ins_dst (ins_dst), .ins_tag (ins_tag),
        .cmp_valid (cmp_valid), .cmp_tag (cmp_tag),
        .win_full (win_full), .issue_valid (issue_valid), .issue_tag (issue_tag),
        .done_mask (done_mask)
    );

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    tag;
        int    at;
        string req;
    } exp_t;
    exp_t sb[$];

    // Scoreboard push, kept ordered by expected cycle.
    function automatic void expect_issue(int tag, int at, string req);
        exp_t it;
        int pos;
        it.tag = tag; it.at = at; it.req = req;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > at) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compares every issue against the scoreboard front.
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].at < cyc) begin
                n_checks++; n_fails++;
                $display("FAIL %s missing issue: actual none expected tag %0d at cycle %0d",
                         sb[0].req, sb[0].tag, sb[0].at);
                void'(sb.pop_front());
            end
            if (issue_valid) begin
                n_checks++;
                if (sb.size() > 0 && sb[0].at == cyc && sb[0].tag == int'(issue_tag)) begin
                    void'(sb.pop_front());
                end else begin
                    n_fails++;
                    if (sb.size() > 0)
                        $display("FAIL %s issue: actual tag %0d at cycle %0d expected tag %0d at cycle %0d",
                                 sb[0].req, issue_tag, cyc, sb[0].tag, sb[0].at);
                    else
                        $display("FAIL R2 issue: actual tag %0d at cycle %0d expected none",
                                 issue_tag, cyc);
                end
            end else if (sb.size() > 0 && sb[0].at == cyc) begin
                n_checks++; n_fails++;
                $display("FAIL %s missing issue: actual none expected tag %0d at cycle %0d",
                         sb[0].req, sb[0].tag, sb[0].at);
                void'(sb.pop_front());
            end
        end
    end

    // Driver: one cycle of stimulus, returns the edge number that sampled it.
    task automatic step(input bit iv, input int sa, input int sbr, input int d, input int t,
                        input bit cv, input int ct, output int e);
        ins_valid = iv;
        ins_src_a = RW'(sa); ins_src_b = RW'(sbr); ins_dst = RW'(d); ins_tag = TW'(t);
        cmp_valid = cv; cmp_tag = TW'(ct);
        @(posedge clk); #1;
        e = cyc;
        @(negedge clk);
        ins_valid = 1'b0; cmp_valid = 1'b0;
    endtask

    task automatic ins(input int sa, input int sbr, input int d, input int t, output int e);
        step(1'b1, sa, sbr, d, t, 1'b0, 0, e);
    endtask

    task automatic cmp(input int t, output int e);
        step(1'b0, 0, 0, 0, 0, 1'b1, t, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        int e;
        int c;
        rst = 1'b1;
        ins_valid = 1'b0; cmp_valid = 1'b0;
        ins_src_a = '0; ins_src_b = '0; ins_dst = '0; ins_tag = '0; cmp_tag = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "win_full", int'(win_full), 0);
        check("R1", "issue_valid", int'(issue_valid), 0);
        check("R1", "done_mask", int'(done_mask != '0), 0);

        // R2 independent instruction
        ins(0, 0, 5, 1, e); expect_issue(1, e + LAT, "R2");
        idle(3);
        cmp(1, c);
        check("R8", "done bit after completion", int'(done_mask[1]), 1);

        // R3 single producer
        ins(0, 0, 6, 2, e); expect_issue(2, e + LAT, "R2");
        ins(6, 0, 7, 3, e);
        idle(3);
        cmp(2, c); expect_issue(3, c + LAT, "R3");
        check("R8", "done bit of completed producer", int'(done_mask[2]), 1);
        check("R8", "done bit of waiting consumer", int'(done_mask[3]), 0);
        idle(3);

        // R3 two producers
        ins(0, 0, 8, 4, e); expect_issue(4, e + LAT, "R2");
        ins(0, 0, 9, 5, e); expect_issue(5, e + LAT, "R2");
        ins(8, 9, 0, 6, e);
        idle(3);
        cmp(4, c);
        idle(4);
        cmp(5, c); expect_issue(6, c + LAT, "R3");
        idle(3);

        // R5 older writer completes, younger writer stays in the table
        ins(0, 0, 10, 7, e); expect_issue(7, e + LAT, "R2");
        ins(0, 0, 10, 8, e); expect_issue(8, e + LAT, "R2");
        idle(3);
        cmp(7, c);
        ins(10, 0, 0, 9, e);
        idle(4);
        cmp(8, c); expect_issue(9, c + LAT, "R5");
        idle(3);

        // R3 same producer twice, R4 read-and-write of one register
        ins(0, 0, 11, 10, e); expect_issue(10, e + LAT, "R2");
        ins(11, 11, 11, 11, e);
        ins(11, 0, 0, 12, e);
        idle(3);
        cmp(10, c); expect_issue(11, c + LAT, "R3");
        idle(4);
        cmp(11, c); expect_issue(12, c + LAT, "R4");
        idle(3);

        // R6 register 0 is not tracked
        ins(0, 0, 0, 13, e); expect_issue(13, e + LAT, "R6");
        ins(0, 0, 5, 14, e); expect_issue(14, e + LAT, "R6");
        idle(4);

        // R7 completion and insertion on the same edge
        ins(0, 0, 13, 16, e); expect_issue(16, e + LAT, "R2");
        idle(3);
        step(1'b1, 13, 0, 13, 17, 1'b1, 16, e); expect_issue(17, e + LAT, "R7");
        ins(13, 0, 0, 18, e);
        check("R8", "done bit on same-edge completion", int'(done_mask[16]), 1);
        idle(4);
        cmp(17, c); expect_issue(18, c + LAT, "R7");
        idle(4);

        // R9 full window, dropped insertion; R10 issue order
        ins(0, 0, 20, 20, e); expect_issue(20, e + LAT, "R2");
        idle(3);
        ins(20, 0, 0, 21, e);
        ins(20, 0, 0, 22, e);
        ins(20, 0, 0, 23, e);
        ins(20, 0, 0, 24, e);
        check("R9", "win_full with all slots taken", int'(win_full), 1);
        ins(0, 0, 21, 25, e);
        check("R9", "win_full after dropped insertion", int'(win_full), 1);
        cmp(20, c);
        expect_issue(21, c + LAT,     "R10");
        expect_issue(22, c + LAT + 1, "R10");
        expect_issue(23, c + LAT + 2, "R10");
        expect_issue(24, c + LAT + 3, "R10");
        idle(6);
        check("R9", "win_full after slots drain", int'(win_full), 0);
        ins(21, 0, 0, 26, e); expect_issue(26, e + LAT, "R9");
        idle(3);

        // R8 reuse of a finished tag clears its done bit
        ins(0, 0, 0, 1, e); expect_issue(1, e + LAT, "R8");
        check("R8", "done bit after reinsertion", int'(done_mask[1]), 0);
        idle(6);

        check("R3", "scoreboard drained", sb.size(), 0);
        summary();
    end
endmodule